// File: doc/BRIEF.md
# Debug Trigger Register Front End

This block is the register side of a hardware breakpoint unit. Several triggers share one small window of control registers. An index register picks which trigger the data registers reach. Each trigger keeps three data words. The first word carries a 4-bit kind code, a lock bit that reserves the trigger for the debugger, and free configuration bits. The block also keeps two software context numbers and a pair of enable bits. The pair is pushed on a trap into machine mode and popped on return.

Accesses arrive on a single-cycle register port. Each access carries its address, the current privilege level and a debug-mode flag. The block decides whether the access is allowed, then updates the addressed register or returns its value one cycle later. It raises an illegal-access pulse when it rejects an access. All trigger data words are presented in parallel on flat output vectors, together with the enable bits, so the comparison logic can use them. Matching, chaining and hit actions live in that comparison logic, not here.

Top module: `dbg_trig_csr`

## Requirements
- R1: After reset the index reads 0, every trigger's first word reads 0x2000_0000 (kind 2 in bits 31:28, lock bit 27 clear), the second and third words and both context registers read 0, the enable pair reads 0, and the illegal flag is low.
- R2: Writing the index (0x7a0) with a value at or above the trigger count (default 4) stores the count minus 1. A smaller value is stored unchanged.
- R3: Accesses to 0x7a1/0x7a2/0x7a3 reach only the trigger named by the index. Each trigger's words appear on the parallel outputs at offset index*32.
- R4: From user mode (privilege 0) every address of the set is rejected. From supervisor mode (privilege 1) only the supervisor context at 0x7aa is accepted. Machine mode (privilege 3) and debug mode accept all addresses.
- R5: When the selected trigger's lock bit (bit 27 of its first word) is set, a write from outside debug mode to any of its three words is rejected.
- R6: Only a debug-mode write changes the lock bit. A machine-mode write to the first word keeps the old lock value and updates the other bits.
- R7: A kind code written to bits 31:28 that is not one of 2, 3, 4 or 5 is stored as 0.
- R8: The info register (0x7a4) reads 0x0000_003C, with one bit set for each supported kind. A write to it is rejected.
- R9: Outside debug mode, writes to the second and third words copy bit 15 into bits 31:16. Debug-mode writes are stored whole.
- R10: The machine context (0x7a8) keeps only its low 6 bits. The supervisor context (0x7aa) keeps only its low 16 bits. All other bits read 0.
- R11: The control register (0x7a5) holds the current enable in bit 3 and the saved enable in bit 7. A trap-entry strobe copies the current enable into the saved one and clears the current one. A trap-return strobe copies the saved enable back. A strobe wins over a write to the control register in the same cycle.
- R12: A rejected access changes no register. It raises the illegal flag in the cycle after the access, for one cycle only, and that cycle's read data is 0. An accepted read returns its value in the cycle after the access.
- R13: An address outside the set is ignored. It raises no flag, changes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | Access strobe, one cycle per access |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Write data |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| dbg_mode | input | 1 | Core is in debug mode |
| trap_enter | input | 1 | Trap into machine mode taken |
| trap_return | input | 1 | Return from machine mode |
| csr_rdata | output | 32 | Read data, one cycle after the access |
| csr_illegal | output | 1 | Access rejected, one-cycle pulse |
| trig_index | output | 2 | Current index |
| trig_word1 | output | 128 | First words of all triggers |
| trig_word2 | output | 128 | Second words of all triggers |
| trig_word3 | output | 128 | Third words of all triggers |
| trig_en | output | 1 | Current machine-mode trigger enable |
| trig_en_saved | output | 1 | Saved enable |
| mctx_value | output | 6 | Machine context |
| sctx_value | output | 16 | Supervisor context |

## Verification
Assertions watch several rules on every cycle. The index never leaves the trigger range. A rejected access leaves the index unchanged. A lock bit can only rise after a debug-mode cycle. No write strobe reaches a locked trigger from outside debug mode. Both trap strobes move the enable pair correctly. The bench scenarios cover the rest, which needs chosen values at the ports: clamping, routing to the chosen trigger, kind legalization, sign extension, context truncation, the info value, and strobes that collide with a write.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam logic [11:0] ADR_INDEX = 12'h7a0;
  localparam logic [11:0] ADR_WORD1 = 12'h7a1;
  localparam logic [11:0] ADR_WORD2 = 12'h7a2;
  localparam logic [11:0] ADR_WORD3 = 12'h7a3;
  localparam logic [11:0] ADR_INFO  = 12'h7a4;
  localparam logic [11:0] ADR_CTRL  = 12'h7a5;
  localparam logic [11:0] ADR_MCTX  = 12'h7a8;
  localparam logic [11:0] ADR_SCTX  = 12'h7aa;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int EN_BIT    = 3;
  localparam int SAVED_BIT = 7;

  typedef struct packed {
    logic index;
    logic word1;
    logic word2;
    logic word3;
    logic info;
    logic ctrl;
    logic mctx;
    logic sctx;
  } reg_hit_t;
endpackage

// File: rtl/dbg_trig_access.sv
module dbg_trig_access
  import dbg_trig_pkg::*;
(
  input  logic        valid_i,
  input  logic        write_i,
  input  logic [11:0] addr_i,
  input  logic [1:0]  priv_i,
  input  logic        dbg_i,
  input  logic        sel_locked_i,
  output reg_hit_t    hit_o,
  output logic        rd_ok_o,
  output logic        wr_ok_o,
  output logic        reject_o
);
  logic any_hit, priv_ok, lock_block, ro_block;

  always_comb begin
    hit_o.index = (addr_i == ADR_INDEX);
    hit_o.word1 = (addr_i == ADR_WORD1);
    hit_o.word2 = (addr_i == ADR_WORD2);
    hit_o.word3 = (addr_i == ADR_WORD3);
    hit_o.info  = (addr_i == ADR_INFO);
    hit_o.ctrl  = (addr_i == ADR_CTRL);
    hit_o.mctx  = (addr_i == ADR_MCTX);
    hit_o.sctx  = (addr_i == ADR_SCTX);
    any_hit     = |hit_o;
    priv_ok     = dbg_i || (priv_i == PRV_M) ||
                  (hit_o.sctx && (priv_i == PRV_S));
    lock_block  = write_i && sel_locked_i && !dbg_i &&
                  (hit_o.word1 || hit_o.word2 || hit_o.word3);
    ro_block    = write_i && hit_o.info;
    reject_o    = valid_i && any_hit && (!priv_ok || lock_block || ro_block);
    wr_ok_o     = valid_i && write_i && any_hit && !reject_o;
    rd_ok_o     = valid_i && !write_i && any_hit && !reject_o;
  end
endmodule

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank #(
  parameter int          DXLEN      = 32,
  parameter int          MXLEN      = 16,
  parameter int          NUM_TRIG   = 4,
  parameter logic [15:0] KIND_MASK  = 16'h003C,
  parameter logic [3:0]  RESET_KIND = 4'd2,
  localparam int         SEL_W      = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1,
  localparam int         LOCK_BIT   = DXLEN - 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic                      wr_w1_i,
  input  logic                      wr_w2_i,
  input  logic                      wr_w3_i,
  input  logic                      dbg_i,
  input  logic [DXLEN-1:0]          wdata_i,
  output logic [NUM_TRIG*DXLEN-1:0] w1_flat_o,
  output logic [NUM_TRIG*DXLEN-1:0] w2_flat_o,
  output logic [NUM_TRIG*DXLEN-1:0] w3_flat_o,
  output logic [DXLEN-1:0]          sel_w1_o,
  output logic [DXLEN-1:0]          sel_w2_o,
  output logic [DXLEN-1:0]          sel_w3_o,
  output logic                      sel_locked_o
);
  logic [DXLEN-1:0] w1_q [NUM_TRIG];
  logic [DXLEN-1:0] w2_q [NUM_TRIG];
  logic [DXLEN-1:0] w3_q [NUM_TRIG];
  logic [3:0]       new_kind;
  logic [DXLEN-1:0] ext_data;

  always_comb begin
    new_kind = KIND_MASK[wdata_i[DXLEN-1 -: 4]] ? wdata_i[DXLEN-1 -: 4] : 4'd0;
    ext_data = wdata_i;
    if (!dbg_i) begin
      for (int b = MXLEN; b < DXLEN; b++) ext_data[b] = wdata_i[MXLEN-1];
    end
  end

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    logic hit_me;
    assign hit_me = (sel_i == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        w1_q[i] <= {RESET_KIND, {(DXLEN-4){1'b0}}};
        w2_q[i] <= '0;
        w3_q[i] <= '0;
      end else begin
        if (wr_w1_i && hit_me)
          w1_q[i] <= {new_kind,
                      dbg_i ? wdata_i[LOCK_BIT] : w1_q[i][LOCK_BIT],
                      wdata_i[LOCK_BIT-1:0]};
        if (wr_w2_i && hit_me) w2_q[i] <= ext_data;
        if (wr_w3_i && hit_me) w3_q[i] <= ext_data;
      end
    end

    assign w1_flat_o[i*DXLEN +: DXLEN] = w1_q[i];
    assign w2_flat_o[i*DXLEN +: DXLEN] = w2_q[i];
    assign w3_flat_o[i*DXLEN +: DXLEN] = w3_q[i];

    // R6: lock bit rises only after a debug-mode cycle
    a_r6_lock_from_debug: assert property (@(posedge clk) disable iff (rst)
      $rose(w1_q[i][LOCK_BIT]) |-> $past(dbg_i));
  end

  assign sel_w1_o     = w1_q[sel_i];
  assign sel_w2_o     = w2_q[sel_i];
  assign sel_w3_o     = w3_q[sel_i];
  assign sel_locked_o = w1_q[sel_i][LOCK_BIT];

  // R5: no write strobe reaches a locked trigger from outside debug mode
  a_r5_locked_no_write: assert property (@(posedge clk) disable iff (rst)
    !((wr_w1_i || wr_w2_i || wr_w3_i) && sel_locked_o && !dbg_i));
endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
#(
  parameter int DXLEN  = 32,
  parameter int MCTX_W = 6,
  parameter int SCTX_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl_i,
  input  logic              wr_mctx_i,
  input  logic              wr_sctx_i,
  input  logic [DXLEN-1:0]  wdata_i,
  input  logic              trap_enter_i,
  input  logic              trap_return_i,
  output logic              en_o,
  output logic              saved_o,
  output logic [MCTX_W-1:0] mctx_o,
  output logic [SCTX_W-1:0] sctx_o
);
  logic en_q, saved_q;
  logic [MCTX_W-1:0] mctx_q;
  logic [SCTX_W-1:0] sctx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      saved_q <= 1'b0;
    end else if (trap_enter_i) begin
      saved_q <= en_q;
      en_q    <= 1'b0;
    end else if (trap_return_i) begin
      en_q    <= saved_q;
    end else if (wr_ctrl_i) begin
      en_q    <= wdata_i[EN_BIT];
      saved_q <= wdata_i[SAVED_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mctx_q <= '0;
      sctx_q <= '0;
    end else begin
      if (wr_mctx_i) mctx_q <= wdata_i[MCTX_W-1:0];
      if (wr_sctx_i) sctx_q <= wdata_i[SCTX_W-1:0];
    end
  end

  assign en_o    = en_q;
  assign saved_o = saved_q;
  assign mctx_o  = mctx_q;
  assign sctx_o  = sctx_q;

  // R11: trap entry pushes the enable and clears it
  a_r11_enter_push: assert property (@(posedge clk) disable iff (rst)
    trap_enter_i |=> (!en_q && saved_q == $past(en_q)));
  // R11: trap return restores the saved enable
  a_r11_return_pop: assert property (@(posedge clk) disable iff (rst)
    (trap_return_i && !trap_enter_i) |=> (en_q == $past(saved_q)));
endmodule

// File: rtl/dbg_trig_csr.sv
module dbg_trig_csr
  import dbg_trig_pkg::*;
#(
  parameter int          DXLEN      = 32,
  parameter int          MXLEN      = 16,
  parameter int          NUM_TRIG   = 4,
  parameter int          MCTX_W     = 6,
  parameter int          SCTX_W     = 16,
  parameter logic [15:0] KIND_MASK  = 16'h003C,
  parameter logic [3:0]  RESET_KIND = 4'd2,
  localparam int         SEL_W      = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      csr_valid,
  input  logic                      csr_write,
  input  logic [11:0]               csr_addr,
  input  logic [DXLEN-1:0]          csr_wdata,
  input  logic [1:0]                cur_priv,
  input  logic                      dbg_mode,
  input  logic                      trap_enter,
  input  logic                      trap_return,
  output logic [DXLEN-1:0]          csr_rdata,
  output logic                      csr_illegal,
  output logic [SEL_W-1:0]          trig_index,
  output logic [NUM_TRIG*DXLEN-1:0] trig_word1,
  output logic [NUM_TRIG*DXLEN-1:0] trig_word2,
  output logic [NUM_TRIG*DXLEN-1:0] trig_word3,
  output logic                      trig_en,
  output logic                      trig_en_saved,
  output logic [MCTX_W-1:0]         mctx_value,
  output logic [SCTX_W-1:0]         sctx_value
);
  reg_hit_t         hit;
  logic             rd_ok, wr_ok, reject, sel_locked;
  logic [SEL_W-1:0] sel_q;
  logic [DXLEN-1:0] sel_w1, sel_w2, sel_w3, rd_mux, rdata_q;
  logic             illegal_q;

  dbg_trig_access u_access (
    .valid_i      (csr_valid),
    .write_i      (csr_write),
    .addr_i       (csr_addr),
    .priv_i       (cur_priv),
    .dbg_i        (dbg_mode),
    .sel_locked_i (sel_locked),
    .hit_o        (hit),
    .rd_ok_o      (rd_ok),
    .wr_ok_o      (wr_ok),
    .reject_o     (reject)
  );

  dbg_trig_bank #(
    .DXLEN(DXLEN), .MXLEN(MXLEN), .NUM_TRIG(NUM_TRIG),
    .KIND_MASK(KIND_MASK), .RESET_KIND(RESET_KIND)
  ) u_bank (
    .clk          (clk),
    .rst          (rst),
    .sel_i        (sel_q),
    .wr_w1_i      (wr_ok && hit.word1),
    .wr_w2_i      (wr_ok && hit.word2),
    .wr_w3_i      (wr_ok && hit.word3),
    .dbg_i        (dbg_mode),
    .wdata_i      (csr_wdata),
    .w1_flat_o    (trig_word1),
    .w2_flat_o    (trig_word2),
    .w3_flat_o    (trig_word3),
    .sel_w1_o     (sel_w1),
    .sel_w2_o     (sel_w2),
    .sel_w3_o     (sel_w3),
    .sel_locked_o (sel_locked)
  );

  dbg_trig_ctrl #(.DXLEN(DXLEN), .MCTX_W(MCTX_W), .SCTX_W(SCTX_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .wr_ctrl_i     (wr_ok && hit.ctrl),
    .wr_mctx_i     (wr_ok && hit.mctx),
    .wr_sctx_i     (wr_ok && hit.sctx),
    .wdata_i       (csr_wdata),
    .trap_enter_i  (trap_enter),
    .trap_return_i (trap_return),
    .en_o          (trig_en),
    .saved_o       (trig_en_saved),
    .mctx_o        (mctx_value),
    .sctx_o        (sctx_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_ok && hit.index) begin
      if (csr_wdata >= DXLEN'(NUM_TRIG)) sel_q <= SEL_W'(NUM_TRIG - 1);
      else                               sel_q <= csr_wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit.index: rd_mux = DXLEN'(sel_q);
      hit.word1: rd_mux = sel_w1;
      hit.word2: rd_mux = sel_w2;
      hit.word3: rd_mux = sel_w3;
      hit.info:  rd_mux = DXLEN'(KIND_MASK);
      hit.ctrl: begin
        rd_mux[EN_BIT]    = trig_en;
        rd_mux[SAVED_BIT] = trig_en_saved;
      end
      hit.mctx:  rd_mux = DXLEN'(mctx_value);
      hit.sctx:  rd_mux = DXLEN'(sctx_value);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      rdata_q   <= rd_ok ? rd_mux : '0;
      illegal_q <= reject;
    end
  end

  assign csr_rdata   = rdata_q;
  assign csr_illegal = illegal_q;
  assign trig_index  = sel_q;

  // R2: index always names an existing trigger
  a_r2_index_in_range: assert property (@(posedge clk) disable iff (rst)
    32'(sel_q) < NUM_TRIG);
  // R12: a rejected access leaves the index untouched
  a_r12_reject_keeps_index: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> $stable(sel_q));
  // R12: rejected access returns zero data
  a_r12_reject_zero_data: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> (csr_rdata == '0));
endmodule

// File: tb/dbg_trig_csr_test.sv
module dbg_trig_csr_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         csr_valid = 1'b0, csr_write = 1'b0;
  logic [11:0]  csr_addr = '0;
  logic [31:0]  csr_wdata = '0;
  logic [1:0]   cur_priv = 2'd3;
  logic         dbg_mode = 1'b0, trap_enter = 1'b0, trap_return = 1'b0;
  logic [31:0]  csr_rdata;
  logic         csr_illegal;
  logic [1:0]   trig_index;
  logic [127:0] trig_word1, trig_word2, trig_word3;
  logic         trig_en, trig_en_saved;
  logic [5:0]   mctx_value;
  logic [15:0]  sctx_value;

  int errors = 0, checks = 0;
  logic [31:0] rd;
  logic        ill;

  dbg_trig_csr uut (
    .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_write(csr_write),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .cur_priv(cur_priv),
    .dbg_mode(dbg_mode), .trap_enter(trap_enter), .trap_return(trap_return),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .trig_index(trig_index),
    .trig_word1(trig_word1), .trig_word2(trig_word2), .trig_word3(trig_word3),
    .trig_en(trig_en), .trig_en_saved(trig_en_saved),
    .mctx_value(mctx_value), .sctx_value(sctx_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [1:0] p, input logic dbg);
    @(negedge clk);
    csr_valid = 1'b1; csr_write = w; csr_addr = a; csr_wdata = d;
    cur_priv = p; dbg_mode = dbg;
    @(negedge clk);
    csr_valid = 1'b0; csr_write = 1'b0;
    rd = csr_rdata; ill = csr_illegal;
  endtask

  task automatic strobe(input logic ent, input logic ret);
    @(negedge clk);
    trap_enter = ent; trap_return = ret;
    @(negedge clk);
    trap_enter = 1'b0; trap_return = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 illegal", 32'(csr_illegal), 0);
    chk("R1 en", {30'd0, trig_en_saved, trig_en}, 0);
    acc(0, 12'h7a0, 0, 3, 0); chk("R1 index", rd, 0);
    acc(0, 12'h7a1, 0, 3, 0); chk("R1 word1", rd, 32'h2000_0000);
    chk("R1 word1 trig3", trig_word1[96 +: 32], 32'h2000_0000);
    acc(0, 12'h7a2, 0, 3, 0); chk("R1 word2", rd, 0);
    acc(0, 12'h7a5, 0, 3, 0); chk("R1 ctrl", rd, 0);
  endtask

  task automatic t_clamp;
    acc(1, 12'h7a0, 9, 3, 0); acc(0, 12'h7a0, 0, 3, 0); chk("R2 clamp 9", rd, 3);
    acc(1, 12'h7a0, 4, 3, 0); acc(0, 12'h7a0, 0, 3, 0); chk("R2 clamp 4", rd, 3);
    acc(1, 12'h7a0, 2, 3, 0); acc(0, 12'h7a0, 0, 3, 0); chk("R2 in range", rd, 2);
  endtask

  task automatic t_route;
    acc(1, 12'h7a0, 1, 3, 1); acc(1, 12'h7a2, 32'h0000_1234, 3, 1);
    acc(1, 12'h7a0, 2, 3, 1); acc(1, 12'h7a2, 32'h0000_5555, 3, 1);
    acc(1, 12'h7a0, 1, 3, 1); acc(0, 12'h7a2, 0, 3, 1);
    chk("R3 read trig1", rd, 32'h1234);
    chk("R3 out trig1", trig_word2[32 +: 32], 32'h1234);
    chk("R3 out trig2", trig_word2[64 +: 32], 32'h5555);
    chk("R3 out trig0", trig_word2[0 +: 32], 0);
  endtask

  task automatic t_priv;
    acc(1, 12'h7a0, 0, 0, 0); chk("R4 user reject", 32'(ill), 1);
    chk("R12 index kept", 32'(trig_index), 1);
    @(negedge clk); chk("R12 pulse one cycle", 32'(csr_illegal), 0);
    acc(1, 12'h7a8, 5, 1, 0); chk("R4 super mctx reject", 32'(ill), 1);
    chk("R12 mctx kept", 32'(mctx_value), 0);
    acc(1, 12'h7aa, 32'h0000_00A5, 1, 0); chk("R4 super sctx ok", 32'(ill), 0);
    acc(0, 12'h7aa, 0, 0, 0); chk("R4 user sctx reject", 32'(ill), 1);
    chk("R12 reject data", rd, 0);
    acc(0, 12'h7aa, 0, 1, 0); chk("R4 super sctx read", rd, 32'hA5);
  endtask

  task automatic t_lock;
    acc(1, 12'h7a0, 0, 3, 1);
    acc(1, 12'h7a1, 32'h2800_00AA, 3, 1);
    acc(0, 12'h7a1, 0, 3, 0); chk("R6 debug sets lock", rd, 32'h2800_00AA);
    acc(1, 12'h7a2, 32'h0000_0077, 3, 0); chk("R5 locked reject", 32'(ill), 1);
    chk("R5 word2 kept", trig_word2[0 +: 32], 0);
    acc(1, 12'h7a1, 32'h2000_0000, 3, 0); chk("R5 locked word1", 32'(ill), 1);
    chk("R5 word1 kept", trig_word1[0 +: 32], 32'h2800_00AA);
    acc(1, 12'h7a0, 1, 3, 0);
    acc(1, 12'h7a1, 32'h3800_0001, 3, 0); chk("R6 m write ok", 32'(ill), 0);
    acc(0, 12'h7a1, 0, 3, 0); chk("R6 lock ignored", rd, 32'h3000_0001);
  endtask

  task automatic t_kind;
    acc(1, 12'h7a0, 2, 3, 0);
    acc(1, 12'h7a1, 32'h7000_0005, 3, 0); acc(0, 12'h7a1, 0, 3, 0);
    chk("R7 kind 7", rd, 32'h0000_0005);
    acc(1, 12'h7a1, 32'hF000_0000, 3, 0); acc(0, 12'h7a1, 0, 3, 0);
    chk("R7 kind 15", rd, 0);
    acc(1, 12'h7a1, 32'h5000_0010, 3, 0); acc(0, 12'h7a1, 0, 3, 0);
    chk("R7 kind 5", rd, 32'h5000_0010);
  endtask

  task automatic t_info;
    acc(0, 12'h7a4, 0, 3, 0); chk("R8 info", rd, 32'h3C);
    acc(1, 12'h7a4, 32'hFFFF, 3, 1); chk("R8 write reject", 32'(ill), 1);
    acc(0, 12'h7a4, 0, 3, 0); chk("R8 info kept", rd, 32'h3C);
  endtask

  task automatic t_sext;
    acc(1, 12'h7a0, 3, 3, 0);
    acc(1, 12'h7a2, 32'h0000_8001, 3, 0); acc(0, 12'h7a2, 0, 3, 0);
    chk("R9 m sext", rd, 32'hFFFF_8001);
    acc(1, 12'h7a2, 32'h0000_8001, 3, 1); acc(0, 12'h7a2, 0, 3, 1);
    chk("R9 debug whole", rd, 32'h0000_8001);
    acc(1, 12'h7a3, 32'h1234_7FFF, 3, 0); acc(0, 12'h7a3, 0, 3, 0);
    chk("R9 word3 sext", rd, 32'h0000_7FFF);
  endtask

  task automatic t_ctx;
    acc(1, 12'h7a8, 32'h0000_FFFF, 3, 0); acc(0, 12'h7a8, 0, 3, 0);
    chk("R10 mctx", rd, 32'h3F);
    acc(1, 12'h7aa, 32'hFFFF_FFFF, 3, 0); acc(0, 12'h7aa, 0, 3, 0);
    chk("R10 sctx", rd, 32'hFFFF);
  endtask

  task automatic t_trap;
    acc(1, 12'h7a5, 32'h8, 3, 0); chk("R11 en set", 32'(trig_en), 1);
    strobe(1, 0);
    chk("R11 enter", {30'd0, trig_en_saved, trig_en}, 32'b10);
    acc(0, 12'h7a5, 0, 3, 0); chk("R11 ctrl read", rd, 32'h80);
    strobe(0, 1);
    chk("R11 return", {30'd0, trig_en_saved, trig_en}, 32'b11);
    @(negedge clk);
    csr_valid = 1; csr_write = 1; csr_addr = 12'h7a5; csr_wdata = 0;
    cur_priv = 3; dbg_mode = 0; trap_enter = 1;
    @(negedge clk);
    csr_valid = 0; csr_write = 0; trap_enter = 0;
    chk("R11 strobe wins", {30'd0, trig_en_saved, trig_en}, 32'b10);
  endtask

  task automatic t_other;
    acc(1, 12'h300, 32'hFFFF_FFFF, 0, 0); chk("R13 no flag", 32'(ill), 0);
    acc(0, 12'h7a6, 0, 3, 0); chk("R13 read zero", rd, 0);
    chk("R13 index kept", 32'(trig_index), 3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset; t_clamp; t_route; t_priv; t_lock;
    t_kind; t_info; t_sext; t_ctx; t_trap; t_other;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule